// File: doc/BRIEF.md
# CAN Interrupt Flag and Error Capture Register

This block holds the host-visible interrupt and capture word of a CAN controller, together with a small global status byte. The protocol engine delivers single-cycle event pulses (receive, transmit, warning, bus error, arbitration loss and others). Each pulse sets a flag in the interrupt word. A bus error also records its error class, direction and frame segment. An arbitration loss records the bit position at which it happened. The host reads the word through a simple read strobe with byte-lane enables.

Every read clears all flags and releases both capture fields, whatever lanes it selects. The read data shows the values from before the read, and the clearing takes effect on the next clock edge. A capture field is loaded by the first matching event after a release and then stays locked. Its value is not erased by later good traffic, by reads, or by the controller entering and leaving its reset mode. Only a newer captured event or hardware reset changes it.

The status byte carries a transmit-complete bit. A successful transmission sets it. Starting a transmission clears it. A failed or aborted transmission leaves it clear.

Top module: `can_irq_capture`

## Requirements
- R1: Pulse `evt_in[k]` sets interrupt word bit k+1 (bits 1 to 10) on the next clock edge. Any read (`rd_en` high for one cycle) clears all of bits 1 to 10 on the following edge.
- R2: During a read, `rd_data` shows the word as it was before that read. Word bit 0 and bits 11 to 15 read as zero.
- R3: A read clears and releases exactly as a full-word read does, whatever the value of `rd_be`. Lanes whose `rd_be` bit is low read as zero. `rd_data` is zero when `rd_en` is low.
- R4: A bus error is signalled on `evt_in[6]` (word bit 7). When the bus-error capture is released, it loads `berr_seg` into bits 16-20, `berr_dir` into bit 21 and `berr_kind` into bits 22-23, and then locks. While it is locked, further bus errors leave it unchanged until a read.
- R5: An arbitration loss is signalled on `evt_in[8]` (word bit 9). It loads `alost_pos` into bits 24-28 under the same release-and-lock rule. Bits 29-31 read as zero.
- R6: A read releases a capture field but keeps its value. Transmit success, receive events and `ctl_reset_mode` never change a captured value.
- R7: An event pulse in the same cycle as a read wins. The flag is set after that edge. A capture event in the same cycle as a read loads the field and leaves it locked.
- R8: Status bit 3 (transmit complete) is 1 after reset. An accepted `tx_start` clears it, and only `tx_ok` sets it. `tx_fail` and `tx_abort` leave it at 0. If `tx_start` and `tx_ok` arrive in the same cycle, the start wins.
- R9: `tx_start` is accepted only while `ctl_reset_mode` is low. Status bit 5 (busy) is set by an accepted start and cleared by `tx_ok`, `tx_fail` or `tx_abort`. All other status bits read as zero.
- R10: After reset, the flags and both capture fields are zero and released, and the status byte is 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | 10 | Event pulses, one per interrupt flag |
| berr_kind | input | 2 | Bus error class, valid with evt_in[6] |
| berr_dir | input | 1 | Bus error direction, valid with evt_in[6] |
| berr_seg | input | 5 | Frame segment of bus error, valid with evt_in[6] |
| alost_pos | input | 5 | Arbitration-lost bit position, valid with evt_in[8] |
| tx_start | input | 1 | Transmission starts |
| tx_ok | input | 1 | Transmission finished successfully |
| tx_fail | input | 1 | Transmission failed |
| tx_abort | input | 1 | Transmission aborted by command |
| ctl_reset_mode | input | 1 | Controller held in its reset mode |
| rd_en | input | 1 | Host read of the interrupt word |
| rd_be | input | 4 | Byte-lane enables of the read |
| rd_data | output | 32 | Interrupt and capture word (pre-read values) |
| stat_data | output | 8 | Global status byte |

## Verification
The bench checks that a read with a single byte lane clears every flag and releases both captures. A design that decoded lanes would leave upper flags set or keep a field locked. It sends a second bus error while the capture is locked, and a third after the release. A design without the lock would show the newest error instead of the first. A design without the release would never show the third. It checks captured fields across successful transmissions, receive events and a reset-mode excursion, which catches a design that zeroes them on good traffic. It collides events with reads, where a clear-priority design would drop the event. It also sends abort and fail after a start, and a start while in reset mode, to catch a transmit-complete bit that is set by the wrong cause.

// File: rtl/can_icr_pkg.sv
package can_icr_pkg;
  localparam int WORD_W    = 32;
  localparam int FLAG_W    = 10;
  localparam int FLAG_LSB  = 1;
  localparam int CAP_W     = 8;
  localparam int BERR_LSB  = 16;
  localparam int ALOST_LSB = 24;
  localparam int BERR_IDX  = 6;
  localparam int ALOST_IDX = 8;
  localparam int POS_W     = 5;
  localparam int STAT_W    = 8;
  localparam int LANES     = WORD_W / 8;
  localparam int GAP_W     = BERR_LSB - FLAG_LSB - FLAG_W;

  typedef struct packed {
    logic [1:0]       kind;
    logic             dir;
    logic [POS_W-1:0] seg;
  } berr_info_t;

  function automatic logic [CAP_W-1:0] pack_alost(input logic [POS_W-1:0] pos);
    return {{(CAP_W-POS_W){1'b0}}, pos};
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(input logic [FLAG_W-1:0] flags,
                                                  input logic [CAP_W-1:0]  berr,
                                                  input logic [CAP_W-1:0]  alost);
    return {alost, berr, {GAP_W{1'b0}}, flags, 1'b0};
  endfunction

  function automatic logic [WORD_W-1:0] lane_mask(input logic [LANES-1:0] be);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction
endpackage

// File: rtl/can_evt_flags.sv
module can_evt_flags #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         clr,
  output logic [W-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= evt | (clr ? '0 : flags);
  end
endmodule

// File: rtl/can_capture_slot.sv
module can_capture_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  input  logic         release_i,
  input  logic [W-1:0] din,
  output logic [W-1:0] value,
  output logic         locked
);
  logic take;
  assign take = hit && (!locked || release_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value  <= '0;
      locked <= 1'b0;
    end else begin
      if (take) value <= din;
      if (take)           locked <= 1'b1;
      else if (release_i) locked <= 1'b0;
    end
  end
endmodule

// File: rtl/can_tx_status.sv
module can_tx_status (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ok,
  input  logic fail,
  input  logic abort,
  input  logic reset_mode,
  output logic complete,
  output logic busy
);
  logic start_acc;
  assign start_acc = start && !reset_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      complete <= 1'b1;
      busy     <= 1'b0;
    end else if (start_acc) begin
      complete <= 1'b0;
      busy     <= 1'b1;
    end else begin
      if (ok) complete <= 1'b1;
      if (ok || fail || abort) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/can_irq_capture.sv
module can_irq_capture
  import can_icr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] evt_in,
  input  logic [1:0]        berr_kind,
  input  logic              berr_dir,
  input  logic [POS_W-1:0]  berr_seg,
  input  logic [POS_W-1:0]  alost_pos,
  input  logic              tx_start,
  input  logic              tx_ok,
  input  logic              tx_fail,
  input  logic              tx_abort,
  input  logic              ctl_reset_mode,
  input  logic              rd_en,
  input  logic [LANES-1:0]  rd_be,
  output logic [WORD_W-1:0] rd_data,
  output logic [STAT_W-1:0] stat_data
);
  logic [FLAG_W-1:0] flags_q;
  logic              berr_evt, alost_evt;
  berr_info_t        berr_info;
  logic [CAP_W-1:0]  berr_din, alost_din;
  logic [CAP_W-1:0]  berr_q, alost_q;
  logic              berr_lock, alost_lock;
  logic              txc, tx_busy;

  assign berr_evt  = evt_in[BERR_IDX];
  assign alost_evt = evt_in[ALOST_IDX];
  assign berr_info = '{kind: berr_kind, dir: berr_dir, seg: berr_seg};
  assign berr_din  = berr_info;
  assign alost_din = pack_alost(alost_pos);

  can_evt_flags #(.W(FLAG_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt_in), .clr(rd_en), .flags(flags_q)
  );

  can_capture_slot #(.W(CAP_W)) u_berr (
    .clk(clk), .rst_n(rst_n), .hit(berr_evt), .release_i(rd_en),
    .din(berr_din), .value(berr_q), .locked(berr_lock)
  );

  can_capture_slot #(.W(CAP_W)) u_alost (
    .clk(clk), .rst_n(rst_n), .hit(alost_evt), .release_i(rd_en),
    .din(alost_din), .value(alost_q), .locked(alost_lock)
  );

  can_tx_status u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .ok(tx_ok), .fail(tx_fail),
    .abort(tx_abort), .reset_mode(ctl_reset_mode), .complete(txc), .busy(tx_busy)
  );

  assign rd_data   = rd_en ? (pack_word(flags_q, berr_q, alost_q) & lane_mask(rd_be)) : '0;
  assign stat_data = {2'b00, tx_busy, 1'b0, txc, 3'b000};
endmodule

// File: rtl/can_irq_capture_chk.sv
module can_irq_capture_chk
  import can_icr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [FLAG_W-1:0] evt_in,
  input logic [FLAG_W-1:0] flags_q,
  input logic              berr_evt,
  input logic [CAP_W-1:0]  berr_din,
  input logic [CAP_W-1:0]  berr_q,
  input logic              berr_lock,
  input logic              alost_evt,
  input logic [CAP_W-1:0]  alost_din,
  input logic [CAP_W-1:0]  alost_q,
  input logic              alost_lock,
  input logic              tx_start,
  input logic              tx_ok,
  input logic              ctl_reset_mode,
  input logic [STAT_W-1:0] stat_data
);
  p_clear_on_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> flags_q == $past(evt_in));
  p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> flags_q == ($past(flags_q) | $past(evt_in)));
  p_berr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (berr_lock && !rd_en) |=> $stable(berr_q));
  p_berr_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (berr_evt && (!berr_lock || rd_en)) |=> (berr_q == $past(berr_din)) && berr_lock);
  p_alost_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (alost_lock && !rd_en) |=> $stable(alost_q));
  p_alost_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (alost_evt && (!alost_lock || rd_en)) |=> (alost_q == $past(alost_din)) && alost_lock);
  p_release_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !berr_evt) |=> !berr_lock && $stable(berr_q));
  p_txc_only_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_data[3]) |-> $past(tx_ok));
  p_txc_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && !ctl_reset_mode) |=> !stat_data[3] && stat_data[5]);
endmodule

bind can_irq_capture can_irq_capture_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .evt_in(evt_in), .flags_q(flags_q),
  .berr_evt(berr_evt), .berr_din(berr_din), .berr_q(berr_q), .berr_lock(berr_lock),
  .alost_evt(alost_evt), .alost_din(alost_din), .alost_q(alost_q), .alost_lock(alost_lock),
  .tx_start(tx_start), .tx_ok(tx_ok), .ctl_reset_mode(ctl_reset_mode), .stat_data(stat_data)
);

// File: tb/sim_can_irq_capture.sv
module sim_can_irq_capture;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  evt_in = '0;
  logic [1:0]  berr_kind = '0;
  logic        berr_dir = 1'b0;
  logic [4:0]  berr_seg = '0;
  logic [4:0]  alost_pos = '0;
  logic        tx_start = 0, tx_ok = 0, tx_fail = 0, tx_abort = 0;
  logic        ctl_reset_mode = 0;
  logic        rd_en = 0;
  logic [3:0]  rd_be = 4'hF;
  logic [31:0] rd_data;
  logic [7:0]  stat_data;

  int checks = 0, failures = 0;
  bit done = 0;
  string cur_req = "R10";

  // reference state
  bit [10:1] m_flags;
  bit [7:0]  m_berr, m_alc;
  bit        m_block, m_alock, m_txc, m_busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_irq_capture u0 (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .berr_kind(berr_kind), .berr_dir(berr_dir),
    .berr_seg(berr_seg), .alost_pos(alost_pos), .tx_start(tx_start), .tx_ok(tx_ok),
    .tx_fail(tx_fail), .tx_abort(tx_abort), .ctl_reset_mode(ctl_reset_mode),
    .rd_en(rd_en), .rd_be(rd_be), .rd_data(rd_data), .stat_data(stat_data)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit [31:0] exp_word();
    bit [31:0] w = 0;
    if (!rd_en) return 0;
    for (int i = 1; i <= 10; i++) w[i] = m_flags[i];
    w[23:16] = m_berr;
    w[31:24] = m_alc;
    for (int l = 0; l < 4; l++) if (!rd_be[l]) w[l*8 +: 8] = 8'h00;
    return w;
  endfunction

  // compare, advance the model, cross one edge, drop pulses
  task automatic tick();
    bit [10:1] nf;
    bit acc;
    #1;
    check(cur_req, "rd_data", rd_data, exp_word());
    check(cur_req, "stat_data", {24'h0, stat_data}, {24'h0, 2'b00, m_busy, 1'b0, m_txc, 3'b000});
    for (int i = 1; i <= 10; i++) nf[i] = evt_in[i-1] | (rd_en ? 1'b0 : m_flags[i]);
    if (evt_in[6] && (!m_block || rd_en)) begin
      m_berr = {berr_kind, berr_dir, berr_seg}; m_block = 1;
    end else if (rd_en) m_block = 0;
    if (evt_in[8] && (!m_alock || rd_en)) begin
      m_alc = {3'b000, alost_pos}; m_alock = 1;
    end else if (rd_en) m_alock = 0;
    acc = tx_start && !ctl_reset_mode;
    if (acc) begin m_txc = 0; m_busy = 1; end
    else begin
      if (tx_ok) m_txc = 1;
      if (tx_ok || tx_fail || tx_abort) m_busy = 0;
    end
    m_flags = nf;
    @(posedge clk);
    @(negedge clk);
    evt_in = '0; tx_start = 0; tx_ok = 0; tx_fail = 0; tx_abort = 0;
    rd_en = 0; rd_be = 4'hF;
  endtask

  task automatic rd(input logic [3:0] be);
    rd_en = 1; rd_be = be; tick();
  endtask

  task automatic berr(input logic [1:0] k, input logic d, input logic [4:0] s);
    evt_in[6] = 1; berr_kind = k; berr_dir = d; berr_seg = s;
  endtask

  initial begin
    m_flags = 0; m_berr = 0; m_alc = 0; m_block = 0; m_alock = 0; m_txc = 1; m_busy = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R10: reset state
    cur_req = "R10";
    rd(4'hF);
    tick();

    // R1, R2: flags set, read returns pre-clear word, then cleared
    cur_req = "R1";
    evt_in = 10'b10_0000_0101; tick();
    evt_in = 10'b00_0011_0000; tick();
    cur_req = "R2";
    rd(4'hF);
    rd(4'hF);
    check("R1", "flags cleared after read", 32'(m_flags), 32'h0);

    // R3: single-lane read clears everything and masks lanes
    cur_req = "R3";
    evt_in = 10'b11_1111_1111; alost_pos = 5'd17; berr(2'b10, 1, 5'h0B); tick();
    rd(4'b0100);
    rd(4'b0001);
    rd(4'b1010);
    tick();

    // R4: lock keeps first bus error until a read
    cur_req = "R4";
    berr(2'b01, 0, 5'h13); tick();
    rd(4'hF);
    berr(2'b11, 1, 5'h1F); tick();
    berr(2'b00, 0, 5'h02); tick();
    rd(4'hF);
    berr(2'b00, 1, 5'h05); tick();
    rd(4'hF);

    // R5: arbitration capture
    cur_req = "R5";
    evt_in[8] = 1; alost_pos = 5'd3; tick();
    evt_in[8] = 1; alost_pos = 5'd30; tick();
    rd(4'hF);
    evt_in[8] = 1; alost_pos = 5'd31; tick();
    rd(4'hF);

    // R6: captures survive good traffic and reset mode
    cur_req = "R6";
    tx_start = 1; tick();
    tx_ok = 1; tick();
    evt_in[0] = 1; tick();
    ctl_reset_mode = 1; tick(); tick();
    ctl_reset_mode = 0; tick();
    rd(4'hF);
    rd(4'hF);

    // R7: event colliding with read
    cur_req = "R7";
    evt_in = 10'b00_0000_0010; tick();
    evt_in = 10'b00_0000_0010; rd_en = 1; tick();
    rd(4'hF);
    berr(2'b10, 0, 5'h0E); tick();
    berr(2'b01, 1, 5'h07); evt_in[8] = 1; alost_pos = 5'd9; rd_en = 1; tick();
    berr(2'b11, 1, 5'h1A); tick();
    rd(4'hF);
    rd(4'hF);

    // R8: transmit complete only from success
    cur_req = "R8";
    tx_start = 1; tick();
    tx_fail = 1; tick();
    tx_abort = 1; tick();
    tick();
    check("R8", "txc low after fail/abort", 32'(m_txc), 32'h0);
    tx_ok = 1; tick();
    tx_start = 1; tick();
    tx_abort = 1; tick();
    tx_start = 1; tx_ok = 1; tick();
    tx_ok = 1; tick();
    tick();

    // R9: start ignored in reset mode, busy bit
    cur_req = "R9";
    ctl_reset_mode = 1; tx_start = 1; tick();
    tick();
    ctl_reset_mode = 0; tx_start = 1; tick();
    tx_ok = 1; tick();
    tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule